// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called A and B, with one data path in each direction. Each path has its own storage register and its own output enable. A per-direction select decides whether the word driven onto the far bus is the live value from the near bus or the value held in that path's register. Each bus pin is split into an input, an output and an output-enable signal, so the block stays synthesizable and a pad ring or top-level tristate can join them.

Each storage register loads its source bus on a rising `clk` edge when its capture strobe is high. Capture works whether or not the outputs are enabled. The select mux result and the enables are registered, so a change of select cannot leave a transient wrong word on the output. If both directions are enabled at once, each bus carries its own copy of the other. A word captured from A can then be driven back out over B and compared with what was sent. After a synchronous reset, neither bus is driven.

Top module: `reg_bus_xcvr`

## Requirements
- R1: A high `rst` at a `clk` edge clears both storage registers and both data outputs to zero and drops both `a_oe` and `b_oe` to 0 from that edge on.
- R2: When `cap_ab` is 1 at an edge, the A-to-B register takes the value of `a_in`.
- R3: When `sel_ab` is 0 (live) at an edge, `b_out` after that edge equals the `a_in` sampled at it.
- R4: When `sel_ab` is 1 (stored) at an edge, `b_out` after that edge equals the A-to-B register contents held just before that edge.
- R5: `b_oe` after an edge equals the active-high `oe_ab` sampled at it.
- R6: `a_oe` after an edge equals the inverse of the active-low `oe_ba_n` sampled at it.
- R7: The B-to-A path works the same way, using `cap_ba`, `sel_ba` (0 live, 1 stored) and `b_in`, and drives `a_out`.
- R8: A capture strobe loads its register even while that path's output enable is inactive.
- R9: While a capture strobe is 0, its register keeps its value whatever its source bus does.
- R10: With `oe_ab`=1 and `oe_ba_n`=0 together, both buses are driven in the same cycle, and neither path's data depends on the other's controls.
- R11: `a_out`, `b_out`, `a_oe` and `b_oe` change only at a rising `clk` edge, so a select change gives no transient value within a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registers and the output stage |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 8 | Value seen on bus A |
| a_out | output | 8 | Word to drive onto bus A |
| a_oe | output | 1 | Bus A drive enable, active high |
| b_in | input | 8 | Value seen on bus B |
| b_out | output | 8 | Word to drive onto bus B |
| b_oe | output | 1 | Bus B drive enable, active high |
| oe_ab | input | 1 | Enables driving bus B, active high |
| oe_ba_n | input | 1 | Enables driving bus A, active low |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 stored |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 stored |
| cap_ab | input | 1 | Capture strobe for the A-to-B register |
| cap_ba | input | 1 | Capture strobe for the B-to-A register |

## Verification
On every cycle, the assertions check the capture and hold of each register, the choice between live and stored data on each output, the enable timing and its polarity, and the clearing of the enables by reset. Only the bench's scenarios can show the sequences: a capture made while a path is disabled and then read back in loopback, both directions active together with mixed selects, select toggling while live and stored words differ, and an output that stays the same between the rising edge and the next falling edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Direction index used by the generate loop in the top module.
  localparam int DIR_AB = 0;
  localparam int DIR_BA = 1;
  localparam int NUM_DIRS = 2;

  typedef enum logic {
    SRC_LIVE = 1'b0,
    SRC_HELD = 1'b1
  } src_sel_e;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  // Named load event for the assertions.
  logic load_evt;
  assign load_evt = cap;

  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (load_evt) q <= din;
  end

  // R2 / R7 / R8: a strobe loads the source word.
  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    cap |=> q == $past(din));
  // R9: no strobe, no change.
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(q));
endmodule

// File: rtl/xcvr_outstage.sv
module xcvr_outstage
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  src_sel_e     sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  input  logic         en,
  output logic [W-1:0] dout,
  output logic         drive
);
  function automatic logic [W-1:0] pick_word(src_sel_e s, logic [W-1:0] lv,
                                             logic [W-1:0] hd);
    return (s == SRC_HELD) ? hd : lv;
  endfunction

  logic [W-1:0] next_word;
  assign next_word = pick_word(sel, live, held);

  // Registered mux: the output moves only at the clock edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      drive <= 1'b0;
    end else begin
      dout  <= next_word;
      drive <= en;
    end
  end

  // R3: live selection forwards the source bus.
  assert_live_R3: assert property (@(posedge clk) disable iff (rst)
    (sel == SRC_LIVE) |=> dout == $past(live));
  // R4: stored selection forwards the register contents.
  assert_held_R4: assert property (@(posedge clk) disable iff (rst)
    (sel == SRC_HELD) |=> dout == $past(held));
  // R5 / R6: enable follows one edge later.
  assert_enable_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> drive == $past(en));
endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             oe_ab,
  input  logic             oe_ba_n,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic             cap_ab,
  input  logic             cap_ba
);
  // Per-direction views: index DIR_AB sources A and drives B,
  // index DIR_BA sources B and drives A.
  logic [NUM_DIRS-1:0][WIDTH-1:0] src_bus, held_word, out_word;
  logic [NUM_DIRS-1:0]            cap_v, en_v, drv_v;
  src_sel_e                       sel_v [NUM_DIRS];

  assign src_bus[DIR_AB] = a_in;
  assign src_bus[DIR_BA] = b_in;
  assign cap_v[DIR_AB]   = cap_ab;
  assign cap_v[DIR_BA]   = cap_ba;
  assign en_v[DIR_AB]    = oe_ab;
  assign en_v[DIR_BA]    = ~oe_ba_n;   // polarity normalised here
  assign sel_v[DIR_AB]   = src_sel_e'(sel_ab);
  assign sel_v[DIR_BA]   = src_sel_e'(sel_ba);

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    xcvr_store #(.W(WIDTH)) i_store (
      .clk (clk),
      .rst (rst),
      .cap (cap_v[d]),
      .din (src_bus[d]),
      .q   (held_word[d])
    );
    xcvr_outstage #(.W(WIDTH)) i_out (
      .clk   (clk),
      .rst   (rst),
      .sel   (sel_v[d]),
      .live  (src_bus[d]),
      .held  (held_word[d]),
      .en    (en_v[d]),
      .dout  (out_word[d]),
      .drive (drv_v[d])
    );
  end

  assign b_out = out_word[DIR_AB];
  assign b_oe  = drv_v[DIR_AB];
  assign a_out = out_word[DIR_BA];
  assign a_oe  = drv_v[DIR_BA];

  // R1: reset leaves both buses undriven with cleared outputs.
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!a_oe && !b_oe && a_out == '0 && b_out == '0));
  // R6: active-low enable for the A side.
  assert_a_polarity_R6: assert property (@(posedge clk) disable iff (rst)
    !oe_ba_n |=> a_oe);
  // R10: both directions enabled together drive both buses.
  assert_dual_drive_R10: assert property (@(posedge clk) disable iff (rst)
    (oe_ab && !oe_ba_n) |=> (a_oe && b_oe));
endmodule

// File: tb/test_reg_bus_xcvr.sv
module test_reg_bus_xcvr;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a_in = 8'h00, b_in = 8'h00;
  logic [7:0] a_out, b_out;
  logic       a_oe, b_oe;
  logic       oe_ab = 1'b0, oe_ba_n = 1'b1;
  logic       sel_ab = 1'b0, sel_ba = 1'b0, cap_ab = 1'b0, cap_ba = 1'b0;

  int checks = 0, fails = 0;

  // Reference state (behavioural).
  int m_ab = 0, m_ba = 0, m_bout = 0, m_aout = 0, m_boe = 0, m_aoe = 0;

  always #10 clk = ~clk;   // 50 MHz

  reg_bus_xcvr i_reg_bus_xcvr (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One clock: sample early after the edge, advance the model, compare.
  task automatic step(string ph);
    int e_bout, e_aout, e_boe, e_aoe;
    @(posedge clk);
    #3;
    e_bout = b_out; e_aout = a_out; e_boe = b_oe; e_aoe = a_oe;
    @(negedge clk);
    if (rst) begin
      m_ab = 0; m_ba = 0; m_bout = 0; m_aout = 0; m_boe = 0; m_aoe = 0;
    end else begin
      m_bout = sel_ab ? m_ab : int'(a_in);
      m_aout = sel_ba ? m_ba : int'(b_in);
      m_boe  = oe_ab ? 1 : 0;
      m_aoe  = oe_ba_n ? 0 : 1;
      if (cap_ab) m_ab = a_in;
      if (cap_ba) m_ba = b_in;
    end
    chk({ph, " b_out R3/R4"}, b_out, m_bout);
    chk({ph, " a_out R7"}, a_out, m_aout);
    chk({ph, " b_oe R5"}, b_oe, m_boe);
    chk({ph, " a_oe R6"}, a_oe, m_aoe);
    chk({ph, " steady R11"}, int'({e_bout[7:0], e_aout[7:0], e_boe[0], e_aoe[0]}),
        int'({b_out, a_out, b_oe, a_oe}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    step("R1"); step("R1");
    chk("R1 oe", {b_oe, a_oe}, 0);
    chk("R1 data", {b_out, a_out}, 0);
    rst = 1'b0;
    // R1: stored registers read back as zero after reset
    sel_ab = 1'b1; sel_ba = 1'b1;
    step("R1"); step("R1");
    chk("R1 stored zero", {b_out, a_out}, 0);

    // R3: live A to B
    sel_ab = 1'b0; oe_ab = 1'b1;
    for (int i = 0; i < 4; i++) begin
      a_in = 8'h11 * (i + 1);
      step("R3");
    end
    chk("R3 last live", b_out, 8'h44);

    // R8: capture while both paths disabled
    oe_ab = 1'b0; oe_ba_n = 1'b1;
    a_in = 8'hA5; b_in = 8'h3C; cap_ab = 1'b1; cap_ba = 1'b1;
    step("R8");
    // R9: strobes low, buses change
    cap_ab = 1'b0; cap_ba = 1'b0; a_in = 8'hFF; b_in = 8'h00;
    step("R9"); step("R9");
    // R2 / R4: stored word out on B
    sel_ab = 1'b1; oe_ab = 1'b1;
    step("R4"); step("R4");
    chk("R2 stored A5", b_out, 8'hA5);
    chk("R5 b_oe on", b_oe, 1);

    // R7 / R6: stored word out on A, active-low enable
    sel_ba = 1'b1; oe_ba_n = 1'b0;
    step("R7");
    chk("R7 stored 3C", a_out, 8'h3C);
    chk("R6 a_oe on", a_oe, 1);

    // R10: loopback, both enabled, mixed selects and captures
    for (int i = 0; i < 6; i++) begin
      a_in = 8'h20 + 8'(i); b_in = 8'h90 - 8'(i);
      sel_ab = i[0]; sel_ba = ~i[1];
      cap_ab = (i == 2); cap_ba = (i == 3);
      step("R10");
    end
    cap_ab = 1'b0; cap_ba = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
    step("R10"); step("R10");
    chk("R10 A loop", b_out, 8'h22);
    chk("R10 B loop", a_out, 8'h8D);

    // R11: toggle select every cycle, live differs from stored
    a_in = 8'h5A;
    for (int i = 0; i < 6; i++) begin
      sel_ab = ~sel_ab;
      step("R11");
    end

    // R1: reset mid-run
    rst = 1'b1;
    step("R1");
    chk("R1 mid oe", {b_oe, a_oe}, 0);
    rst = 1'b0; oe_ab = 1'b0; oe_ba_n = 1'b1;
    step("R1"); step("R1");
    chk("R1 mid stored", {b_out, a_out}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule